// File: doc/BRIEF.md
# Three/Four-Wire Serial Register Port

This block is a slave control port that lets an external host read and write a bank of 16-bit configuration registers over a slow serial link. The host lowers an active-low frame enable and clocks in one command byte. The top bit of that byte picks read or write, and the low seven bits give the register address. Sixteen data bits follow, most significant bit first. The host presents its bits before rising serial-clock edges. The port launches read data after falling edges, so the host can sample each bit on the next rising edge.

The port supports two wiring options. In three-wire use a single data pin carries the command into the block and then turns around to carry read data out. In four-wire use a second output pin carries the same read data as well. A mode bit held in register 0 selects the option, and the choice applies from the frame after the write. Output drivers appear as data/enable pairs, so the pad ring builds the tri-state buffers. The serial pins are oversampled by the system clock through a synchronizer. A parallel read port gives on-chip logic the current value of every register.

Top module: `spireg_top`

## Requirements
- R1: A write frame has command bit 7 = 0 and address in bits 6..0, followed by 16 data bits sent MSB first. The addressed register takes the word only after the 16th data bit, and the new value appears on `cfg_rdata` when `cfg_addr` selects it.
- R2: A read frame has command bit 7 = 1. The register value is captured when the command byte ends. Its MSB is driven after the first falling serial-clock edge of the data phase, and one further bit follows on each falling edge. Each bit is valid at the following rising edge.
- R3: In three-wire mode (register 0 bit 0 = 0), `sdio_oe` is high during the read data phase and `sdo_oe` never rises.
- R4: In four-wire mode (register 0 bit 0 = 1), `sdio_out` and `sdo_out` both carry the read data, with both enables high during the read data phase.
- R5: After the last data bit of a full read, the active output(s) drive low from the next falling edge until the frame enable rises. Both enables are then released.
- R6: Both output enables stay low while the frame enable is high, during the command byte, and throughout a write data phase.
- R7: A frame that ends before all 24 bits have arrived changes no register, and the next frame starts again at the command byte.
- R8: The mode bit is register 0 bit 0 and resets to three-wire. A write to it takes effect from the next frame.
- R9: Addresses at or above the register count (8) ignore writes and read back as 0.
- R10: After reset every register reads 0 and both output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| sen_n | input | 1 | Active-low frame enable |
| sdio_in | input | 1 | Input level of the bidirectional data pin |
| sdio_out | output | 1 | Output level for the bidirectional data pin |
| sdio_oe | output | 1 | Drive enable for the bidirectional data pin |
| sdo_out | output | 1 | Output level for the dedicated output pin |
| sdo_oe | output | 1 | Drive enable for the dedicated output pin |
| cfg_addr | input | 7 | Parallel read address |
| cfg_rdata | output | 16 | Parallel read data of the addressed register |

## Verification
Two situations are the hardest to reach from the pins. The first is the low tail after the last read bit, and the second is a frame cut off just before its final write bit. The stimulus drives the serial clock by hand, one half-period at a time, so it can stop a frame at any bit count, including 23 bits. It then reads the target register back over the serial link. A mode switch is also written over the link, and the following read is checked bit by bit on both output pins.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 7;
  localparam int CMD_W      = ADDR_W + 1;
  localparam int FRAME_BITS = CMD_W + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef enum logic {
    WIRE3 = 1'b0,
    WIRE4 = 1'b1
  } wire_mode_e;
endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe_q;
  logic [STAGES-1:0][W-1:0] pipe_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign pipe_d[g] = d;
    end else begin : g_next
      assign pipe_d[g] = pipe_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= pipe_d;
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/spireg_bank.sv
module spireg_bank
  import spireg_pkg::*;
#(
  parameter int REG_COUNT = 8,
  parameter int MODE_ADDR = 0,
  parameter int MODE_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] cfg_addr,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              mode_bit
);
  logic [DATA_W-1:0] regs_w [REG_COUNT];

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    logic [DATA_W-1:0] val_q;
    logic [DATA_W-1:0] val_d;
    logic              hit;

    assign hit = we && (waddr == ADDR_W'(g));

    always_comb begin
      val_d = val_q;
      if (hit) val_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end

    assign regs_w[g] = val_q;
  end

  always_comb begin
    rd_data   = '0;
    cfg_rdata = '0;
    for (int i = 0; i < REG_COUNT; i++) begin
      if (rd_addr  == ADDR_W'(i)) rd_data   = regs_w[i];
      if (cfg_addr == ADDR_W'(i)) cfg_rdata = regs_w[i];
    end
  end

  assign mode_bit = regs_w[MODE_ADDR][MODE_BIT];

  AST_MODE_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == ADDR_W'(MODE_ADDR)) |=> (mode_bit == $past(wdata[MODE_BIT]))) else $error("mode write"); // R8
endmodule

// File: rtl/spireg_frame.sv
module spireg_frame
  import spireg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_act,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              din,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_word,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic              dout,
  output logic              drive
);
  localparam logic [CNT_W-1:0] CMD_END   = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(FRAME_BITS);

  logic [CNT_W-1:0]  cnt_q,  cnt_d;
  logic [ADDR_W-1:0] cmd_q,  cmd_d;
  logic              rnw_q,  rnw_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wsh_q,  wsh_d;
  logic [DATA_W-1:0] rsh_q,  rsh_d;
  logic              dout_q, dout_d;
  logic              drv_q,  drv_d;
  logic              we_q,   we_d;

  assign rd_addr = {cmd_q[ADDR_W-2:0], din};

  always_comb begin
    cnt_d  = cnt_q;
    cmd_d  = cmd_q;
    rnw_d  = rnw_q;
    addr_d = addr_q;
    wsh_d  = wsh_q;
    rsh_d  = rsh_q;
    dout_d = dout_q;
    drv_d  = drv_q;
    we_d   = 1'b0;
    if (!frame_act) begin
      cnt_d  = '0;
      drv_d  = 1'b0;
      dout_d = 1'b0;
    end else begin
      if (rise_ev) begin
        if (cnt_q < CMD_END) begin
          cmd_d = {cmd_q[ADDR_W-2:0], din};
          if (cnt_q == CMD_END - 1'b1) begin
            rnw_d  = cmd_q[ADDR_W-1];
            addr_d = rd_addr;
            rsh_d  = rd_word;
          end
        end else if (cnt_q < FRAME_END) begin
          wsh_d = {wsh_q[DATA_W-2:0], din};
          if ((cnt_q == FRAME_END - 1'b1) && !rnw_q) we_d = 1'b1;
        end
        if (cnt_q < FRAME_END) cnt_d = cnt_q + 1'b1;
      end
      if (fall_ev && rnw_q && (cnt_q >= CMD_END)) begin
        drv_d = 1'b1;
        if (cnt_q < FRAME_END) begin
          dout_d = rsh_q[DATA_W-1];
          rsh_d  = {rsh_q[DATA_W-2:0], 1'b0};
        end else begin
          dout_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmd_q  <= '0;
      rnw_q  <= 1'b0;
      addr_q <= '0;
      wsh_q  <= '0;
      rsh_q  <= '0;
      dout_q <= 1'b0;
      drv_q  <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cmd_q  <= cmd_d;
      rnw_q  <= rnw_d;
      addr_q <= addr_d;
      wsh_q  <= wsh_d;
      rsh_q  <= rsh_d;
      dout_q <= dout_d;
      drv_q  <= drv_d;
      we_q   <= we_d;
    end
  end

  assign we    = we_q;
  assign waddr = addr_q;
  assign wdata = wsh_q;
  assign dout  = dout_q;
  assign drive = drv_q;

  AST_WR_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> (cnt_q == FRAME_END && !rnw_q)) else $error("early write"); // R1
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FRAME_END) else $error("count overrun"); // R7
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_act |=> !drv_q) else $error("drive while idle"); // R6
  AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q |-> (rnw_q && cnt_q >= CMD_END)) else $error("drive outside read"); // R6
  AST_TAIL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_act && fall_ev && drv_q && cnt_q == FRAME_END) |=> !dout_q) else $error("tail not low"); // R5
endmodule

// File: rtl/spireg_top.sv
module spireg_top
  import spireg_pkg::*;
#(
  parameter int REG_COUNT   = 8,
  parameter int MODE_ADDR   = 0,
  parameter int MODE_BIT    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sen_n,
  input  logic              sdio_in,
  output logic              sdio_out,
  output logic              sdio_oe,
  output logic              sdo_out,
  output logic              sdo_oe,
  input  logic [ADDR_W-1:0] cfg_addr,
  output logic [DATA_W-1:0] cfg_rdata
);
  logic [1:0] rst_pipe_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  logic [2:0] pins_s;
  logic       sclk_s, sen_s_n, din_s;

  spireg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d     ({sclk, sen_n, sdio_in}),
    .q     (pins_s)
  );
  assign {sclk_s, sen_s_n, din_s} = pins_s;

  logic sclk_prev_q;
  logic frame_act, rise_ev, fall_ev;
  wire_mode_e mode_q, mode_d;
  logic mode_bit;

  assign frame_act = !sen_s_n;
  assign rise_ev   = sclk_s && !sclk_prev_q;
  assign fall_ev   = !sclk_s && sclk_prev_q;

  always_comb begin
    mode_d = mode_q;
    if (!frame_act) mode_d = wire_mode_e'(mode_bit);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      sclk_prev_q <= 1'b0;
      mode_q      <= WIRE3;
    end else begin
      sclk_prev_q <= sclk_s;
      mode_q      <= mode_d;
    end
  end

  logic [ADDR_W-1:0] rd_addr, waddr;
  logic [DATA_W-1:0] rd_word, wdata;
  logic              we, dout, drive;

  spireg_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .frame_act (frame_act),
    .rise_ev   (rise_ev),
    .fall_ev   (fall_ev),
    .din       (din_s),
    .rd_addr   (rd_addr),
    .rd_word   (rd_word),
    .we        (we),
    .waddr     (waddr),
    .wdata     (wdata),
    .dout      (dout),
    .drive     (drive)
  );

  spireg_bank #(.REG_COUNT(REG_COUNT), .MODE_ADDR(MODE_ADDR), .MODE_BIT(MODE_BIT)) u_bank (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .we        (we),
    .waddr     (waddr),
    .wdata     (wdata),
    .rd_addr   (rd_addr),
    .rd_data   (rd_word),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .mode_bit  (mode_bit)
  );

  assign sdio_out = dout;
  assign sdio_oe  = drive;
  assign sdo_out  = dout;
  assign sdo_oe   = drive && (mode_q == WIRE4);

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_s_n)
    (frame_act && $past(frame_act)) |-> $stable(mode_q)) else $error("mode changed mid-frame"); // R8
endmodule

// File: tb/spireg_top_bench.sv
module spireg_top_bench;
  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        sen_n = 1'b1;
  logic        sdio_in = 1'b0;
  logic        sdio_out, sdio_oe, sdo_out, sdo_oe;
  logic [6:0]  cfg_addr = '0;
  logic [15:0] cfg_rdata;

  int checks = 0;
  int fails  = 0;
  bit [15:0] mdl [128];

  always #10 clk = ~clk;

  spireg_top u_spireg_top (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sen_n(sen_n), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
    .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input bit rd, input bit [6:0] a, input bit [15:0] wd, input int nbits);
    bit [7:0]  ins  = {rd, a};
    bit [15:0] ev   = (a < 7'd8) ? mdl[a] : 16'h0000;
    bit        four = mdl[0][0];
    sen_n = 1'b0;
    tick(H);
    for (int i = 0; i < nbits; i++) begin
      sdio_in = (i < 8) ? ins[7-i] : (rd ? 1'b0 : wd[23-i]);
      tick(H);
      if (rd && i >= 8) begin
        check("R2 sdio_oe", 16'(sdio_oe), 16'd1);
        check("R2 data bit", 16'(sdio_out), 16'(ev[23-i]));
        if (four) begin
          check("R4 sdo_oe", 16'(sdo_oe), 16'd1);
          check("R4 sdo bit", 16'(sdo_out), 16'(ev[23-i]));
        end else begin
          check("R3 sdo_oe", 16'(sdo_oe), 16'd0);
        end
      end else begin
        check("R6 enables", {14'd0, sdio_oe, sdo_oe}, 16'd0);
      end
      sclk = 1'b1;
      tick(H);
      sclk = 1'b0;
    end
    tick(H);
    if (rd && nbits == 24) begin
      check("R5 tail oe", 16'(sdio_oe), 16'd1);
      check("R5 tail low", 16'(sdio_out), 16'd0);
      check("R5 tail sdo", {14'd0, sdo_oe, sdo_oe && sdo_out}, {14'd0, four, 1'b0});
    end
    sen_n = 1'b1;
    tick(H);
    check("R5 release", {14'd0, sdio_oe, sdo_oe}, 16'd0);
    if (!rd && nbits == 24 && a < 7'd8) mdl[a] = wd;
    tick(H);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    foreach (mdl[i]) mdl[i] = '0;
    tick(4);
    rst_n = 1'b1;
    tick(6);
    // R10 reset state
    check("R10 enables", {14'd0, sdio_oe, sdo_oe}, 16'd0);
    for (int r = 0; r < 8; r++) begin
      cfg_addr = 7'(r);
      tick(1);
      check("R10 reg zero", cfg_rdata, 16'h0000);
    end
    // R1 write then parallel readback
    run_frame(1'b0, 7'd2, 16'hA5C3, 24);
    cfg_addr = 7'd2; tick(1);
    check("R1 cfg", cfg_rdata, 16'hA5C3);
    // R2 / R3 read in three-wire mode
    run_frame(1'b1, 7'd2, 16'h0, 24);
    run_frame(1'b0, 7'd5, 16'h8001, 24);
    run_frame(1'b1, 7'd5, 16'h0, 24);
    // R7 truncated frames
    run_frame(1'b0, 7'd2, 16'h1234, 10);
    run_frame(1'b0, 7'd2, 16'h1234, 23);
    cfg_addr = 7'd2; tick(1);
    check("R7 unchanged", cfg_rdata, 16'hA5C3);
    run_frame(1'b1, 7'd2, 16'h0, 24);
    // R9 out of range address
    run_frame(1'b0, 7'h40, 16'hFFFF, 24);
    run_frame(1'b1, 7'h40, 16'h0, 24);
    cfg_addr = 7'h40; tick(1);
    check("R9 cfg zero", cfg_rdata, 16'h0000);
    // R8 switch to four-wire, effective next frame
    run_frame(1'b0, 7'd0, 16'h0001, 24);
    cfg_addr = 7'd0; tick(1);
    check("R8 mode reg", cfg_rdata, 16'h0001);
    run_frame(1'b1, 7'd2, 16'h0, 24);
    run_frame(1'b1, 7'd0, 16'h0, 24);
    // R4 write in four-wire keeps outputs quiet, then back to three-wire
    run_frame(1'b0, 7'd7, 16'h5AA5, 24);
    run_frame(1'b1, 7'd7, 16'h0, 24);
    run_frame(1'b0, 7'd0, 16'h0000, 24);
    run_frame(1'b1, 7'd5, 16'h0, 24);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule